// File: doc/BRIEF.md
# Fractional Swallowing Clock Synthesizer

This block derives a slower audio-rate clock enable from a fast reference clock. It counts reference cycles up to an integer divider. On top of that count it keeps a running record of the fractional period error, and it pays off that error one whole reference cycle at a time. When the correction sign asks for a longer period, it inserts a stall cycle during which the divider does not advance. When the sign asks for a shorter period, the divider advances by two in one cycle. The mean output period is therefore exact to one sixteenth of a picosecond. The cost is cycle-to-cycle jitter of one reference cycle.

The reference period and the correction magnitude are both given in sixteenths of a picosecond. The block expects the divider, the magnitude and the sign to have been worked out beforehand by the usual floor/ceiling rounding of the frequency ratio. It latches its settings only while it is disabled. The output is a one-reference-cycle-wide pulse, `tick_o`, meant to drive a clock-enable or a clock gate. A bypass setting holds the pulse high on every reference cycle, so a downstream gate passes the reference clock straight through.

Top module: `fsyn_top`

## Requirements
- R1: While reset is asserted, `tick_o` and `cfg_err_o` are both low, because the latched settings reset to a divider of 2, a reference period of 1 and a zero magnitude.
- R2: The settings `div_i`, `tref_i`, `delta_i`, `sign_i` and `bypass_i` are copied into the block on every clock edge at which `enable_i` is low. Changes made while `enable_i` is high have no effect on `tick_o` or `cfg_err_o`.
- R3: Without bypass, `cfg_err_o` is high when the latched divider is below 2, when the latched reference period is zero, or when twice the magnitude is at least the reference period. While `cfg_err_o` is high, `tick_o` stays low.
- R4: With a zero magnitude, the first pulse after `enable_i` rises appears after the div-th rising edge, and the pulses then repeat every div edges.
- R5: With sign 0 (lengthen), the magnitude is added to an accumulator on each counted reference cycle. Each time the sum reaches the reference period, the period is subtracted and one stall cycle follows. The mean period is div·(tref+delta)/tref reference cycles. For example, div 4, tref 16, delta 4 gives a steady period of 5.
- R6: With sign 1 (shorten), a cycle in which the sum reaches the reference period advances the divider by two and adds the magnitude a second time. The mean period is div·(tref−delta)/tref reference cycles. For example, div 4, tref 16, delta 4 gives a steady period of 3.
- R7: Taking `enable_i` low for one edge clears the accumulator, the divider count and any pending stall, so after re-enabling the first pulse again appears after the div-th edge.
- R8: With the latched bypass set, `cfg_err_o` is low, and `tick_o` is high after every rising edge at which `enable_i` is high.
- R9: While the block runs without bypass, the accumulator stays below the latched reference period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Run when high; latch settings and clear state when low |
| bypass_i | input | 1 | Bypass setting: pulse on every reference cycle |
| div_i | input | DIV_W | Integer divider, in reference cycles |
| tref_i | input | FRAC_W | Reference period in sixteenths of a picosecond |
| delta_i | input | FRAC_W | Per-cycle period correction magnitude, in sixteenths of a picosecond |
| sign_i | input | 1 | 0 lengthens the period, 1 shortens it |
| tick_o | output | 1 | One-cycle output pulse at the synthesized rate |
| cfg_err_o | output | 1 | Latched settings are unusable |

## Verification
`cfg_err_o` follows the settings one edge after they are presented with the block disabled, so the bench reads it after two edges. `tick_o` is registered. With the enable raised between edges, pulse number k of an integer-divided stream is visible just after edge k·div. The bench numbers every rising edge after enable, samples one nanosecond after it, and compares the edge numbers of the first three pulses with values computed from the divider and the stall or skip pattern. For fractional settings it also counts pulses over 300 edges and compares the count with the mean-period formula, within one pulse.

// File: rtl/fsyn_pkg.sv
package fsyn_pkg;
   typedef enum logic {
      SGN_LONG  = 1'b0,
      SGN_SHORT = 1'b1
   } corr_sgn_e;
endpackage

// File: rtl/fsyn_cfg.sv
module fsyn_cfg
   import fsyn_pkg::*;
#(
   parameter int DIV_W  = 8,
   parameter int FRAC_W = 20
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              enable_i,
   input  logic              bypass_i,
   input  logic [DIV_W-1:0]  div_i,
   input  logic [FRAC_W-1:0] tref_i,
   input  logic [FRAC_W-1:0] delta_i,
   input  logic              sign_i,
   output logic [DIV_W-1:0]  div_q,
   output logic [FRAC_W-1:0] tref_q,
   output logic [FRAC_W-1:0] delta_q,
   output corr_sgn_e         sign_q,
   output logic              byp_q,
   output logic              cfg_err
);
   localparam logic [DIV_W-1:0]  DIV_RST  = DIV_W'(2);
   localparam logic [FRAC_W-1:0] TREF_RST = FRAC_W'(1);

   if (DIV_W < 2) begin : g_div_w_bad
      $fatal(1, "fsyn_cfg: DIV_W must be at least 2");
   end
   if (FRAC_W < 2) begin : g_frac_w_bad
      $fatal(1, "fsyn_cfg: FRAC_W must be at least 2");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         div_q   <= DIV_RST;
         tref_q  <= TREF_RST;
         delta_q <= '0;
         sign_q  <= SGN_LONG;
         byp_q   <= 1'b0;
      end else if (!enable_i) begin
         div_q   <= div_i;
         tref_q  <= tref_i;
         delta_q <= delta_i;
         sign_q  <= corr_sgn_e'(sign_i);
         byp_q   <= bypass_i;
      end
   end

   logic div_small, tref_zero, delta_big;
   always_comb begin
      div_small = (div_q < DIV_RST);
      tref_zero = (tref_q == '0);
      delta_big = ({delta_q, 1'b0} >= {1'b0, tref_q});
      cfg_err   = !byp_q && (div_small || tref_zero || delta_big);
   end
endmodule

// File: rtl/fsyn_phase.sv
module fsyn_phase
   import fsyn_pkg::*;
#(
   parameter int FRAC_W = 20
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              run,
   input  logic [FRAC_W-1:0] tref,
   input  logic [FRAC_W-1:0] delta,
   input  corr_sgn_e         sign,
   output logic              hold,
   output logic              dbl,
   output logic [FRAC_W:0]   acc_o
);
   localparam int AW = FRAC_W + 2;

   logic [FRAC_W:0] acc_q, acc_d;
   logic            stall_q, stall_d;
   logic [AW-1:0]   sum, sum_pay, sum_skip, tref_x, delta_x;
   logic            evt;

   always_comb begin
      tref_x   = AW'(tref);
      delta_x  = AW'(delta);
      sum      = AW'(acc_q) + delta_x;
      evt      = (sum >= tref_x);
      sum_pay  = sum - tref_x;
      sum_skip = sum + delta_x - tref_x;
      hold     = 1'b0;
      dbl      = 1'b0;
      acc_d    = acc_q;
      stall_d  = 1'b0;
      if (!run) begin
         acc_d = '0;
      end else if (sign == SGN_LONG) begin
         if (stall_q) begin
            hold = 1'b1;
         end else begin
            acc_d   = evt ? sum_pay[FRAC_W:0] : sum[FRAC_W:0];
            stall_d = evt;
         end
      end else begin
         dbl   = evt;
         acc_d = evt ? sum_skip[FRAC_W:0] : sum[FRAC_W:0];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_q   <= '0;
         stall_q <= 1'b0;
      end else begin
         acc_q   <= acc_d;
         stall_q <= stall_d;
      end
   end

   assign acc_o = acc_q;
endmodule

// File: rtl/fsyn_divcnt.sv
module fsyn_divcnt #(
   parameter int DIV_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run,
   input  logic             byp,
   input  logic [DIV_W-1:0] div,
   input  logic             hold,
   input  logic             dbl,
   output logic             tick
);
   localparam int CW = DIV_W + 1;

   logic [DIV_W-1:0] cnt_q;
   logic [CW-1:0]    adv, nxt, rem;
   logic             wrap;

   always_comb begin
      adv  = hold ? CW'(0) : (dbl ? CW'(2) : CW'(1));
      nxt  = CW'(cnt_q) + adv;
      wrap = (nxt >= CW'(div));
      rem  = nxt - CW'(div);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         tick  <= 1'b0;
      end else if (!run) begin
         cnt_q <= '0;
         tick  <= 1'b0;
      end else if (byp) begin
         cnt_q <= '0;
         tick  <= 1'b1;
      end else if (wrap) begin
         cnt_q <= rem[DIV_W-1:0];
         tick  <= 1'b1;
      end else begin
         cnt_q <= nxt[DIV_W-1:0];
         tick  <= 1'b0;
      end
   end
endmodule

// File: rtl/fsyn_top.sv
module fsyn_top
   import fsyn_pkg::*;
#(
   parameter int DIV_W  = 8,
   parameter int FRAC_W = 20
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              enable_i,
   input  logic              bypass_i,
   input  logic [DIV_W-1:0]  div_i,
   input  logic [FRAC_W-1:0] tref_i,
   input  logic [FRAC_W-1:0] delta_i,
   input  logic              sign_i,
   output logic              tick_o,
   output logic              cfg_err_o
);
   logic [DIV_W-1:0]  div_q;
   logic [FRAC_W-1:0] tref_q, delta_q;
   corr_sgn_e         sign_q;
   logic              byp_q, cfg_err, run, hold, dbl;
   logic [FRAC_W:0]   acc_q;

   fsyn_cfg #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_cfg (
      .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i),
      .bypass_i(bypass_i), .div_i(div_i), .tref_i(tref_i),
      .delta_i(delta_i), .sign_i(sign_i),
      .div_q(div_q), .tref_q(tref_q), .delta_q(delta_q),
      .sign_q(sign_q), .byp_q(byp_q), .cfg_err(cfg_err)
   );

   assign run = enable_i && !cfg_err;

   fsyn_phase #(.FRAC_W(FRAC_W)) u_phase (
      .clk_i(clk_i), .rst_ni(rst_ni), .run(run),
      .tref(tref_q), .delta(delta_q), .sign(sign_q),
      .hold(hold), .dbl(dbl), .acc_o(acc_q)
   );

   fsyn_divcnt #(.DIV_W(DIV_W)) u_div (
      .clk_i(clk_i), .rst_ni(rst_ni), .run(run), .byp(byp_q),
      .div(div_q), .hold(hold), .dbl(dbl), .tick(tick_o)
   );

   assign cfg_err_o = cfg_err;
endmodule

// File: rtl/fsyn_chk.sv
module fsyn_chk #(
   parameter int FRAC_W = 20
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              enable_i,
   input logic              tick_o,
   input logic              cfg_err_o,
   input logic              byp_q,
   input logic              run,
   input logic [FRAC_W:0]   acc_q,
   input logic [FRAC_W-1:0] tref_q
);
   // R3
   err_silences_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_err_o |-> !tick_o);

   // R2
   err_frozen_while_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      enable_i |=> $stable(cfg_err_o));

   // R7
   idle_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !enable_i |=> !tick_o);

   // R8
   bypass_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (enable_i && byp_q) |=> tick_o);

   // R9
   acc_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run && !byp_q) |-> (acc_q < {1'b0, tref_q}));
endmodule

bind fsyn_top fsyn_chk #(.FRAC_W(FRAC_W)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i),
   .tick_o(tick_o), .cfg_err_o(cfg_err_o), .byp_q(byp_q),
   .run(run), .acc_q(acc_q), .tref_q(tref_q)
);

// File: tb/fsyn_top_tb_top.sv
`timescale 1ns/1ps
module fsyn_top_tb_top;
   localparam int DIV_W  = 8;
   localparam int FRAC_W = 20;
   localparam int NV     = 9;

   // div, tref, delta, sign, bypass, expected error, first pulse edge, steady period
   localparam int V_DIV [NV] = '{4, 4, 4, 2, 7, 1, 4, 4, 0};
   localparam int V_TREF[NV] = '{16, 16, 16, 10, 16, 16, 0, 16, 0};
   localparam int V_DLT [NV] = '{0, 4, 4, 0, 0, 0, 0, 8, 0};
   localparam int V_SGN [NV] = '{0, 0, 1, 0, 1, 0, 0, 0, 0};
   localparam int V_BYP [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 1};
   localparam int V_ERR [NV] = '{0, 0, 0, 0, 0, 1, 1, 1, 0};
   localparam int V_FST [NV] = '{4, 4, 4, 2, 7, 0, 0, 0, 1};
   localparam int V_PER [NV] = '{4, 5, 3, 2, 7, 0, 0, 0, 1};

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              enable = 1'b0;
   logic              bypass = 1'b0;
   logic [DIV_W-1:0]  div = '0;
   logic [FRAC_W-1:0] tref = '0;
   logic [FRAC_W-1:0] delta = '0;
   logic              sign = 1'b0;
   logic              tick, cfg_err;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   fsyn_top #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .bypass_i(bypass),
      .div_i(div), .tref_i(tref), .delta_i(delta), .sign_i(sign),
      .tick_o(tick), .cfg_err_o(cfg_err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic setup(input int d, input int t, input int dl, input int s, input int b);
      @(negedge clk);
      enable = 1'b0;
      div    = DIV_W'(d);
      tref   = FRAC_W'(t);
      delta  = FRAC_W'(dl);
      sign   = s[0];
      bypass = b[0];
      repeat (2) @(posedge clk);
      #1;
   endtask

   task automatic run_en(input int ncyc, output int t1, output int t2,
                         output int t3, output int cnt);
      t1 = 0; t2 = 0; t3 = 0; cnt = 0;
      @(negedge clk);
      enable = 1'b1;
      for (int e = 1; e <= ncyc; e++) begin
         @(posedge clk);
         #1;
         if (tick) begin
            cnt++;
            if (cnt == 1) t1 = e;
            else if (cnt == 2) t2 = e;
            else if (cnt == 3) t3 = e;
         end
      end
   endtask

   function automatic string tag(input int i);
      if (V_ERR[i] != 0) return "R3";
      if (V_BYP[i] != 0) return "R8";
      if (V_DLT[i] == 0) return "R4";
      if (V_SGN[i] == 0) return "R5";
      return "R6";
   endfunction

   initial begin
      #800000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int t1, t2, t3, cnt, ex;
      // R1: reset state
      repeat (3) @(posedge clk);
      #1;
      chk(tick == 1'b0, "R1 tick", int'(tick), 0);
      chk(cfg_err == 1'b0, "R1 cfg_err", int'(cfg_err), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // Table of vectors
      for (int i = 0; i < NV; i++) begin
         setup(V_DIV[i], V_TREF[i], V_DLT[i], V_SGN[i], V_BYP[i]);
         chk(int'(cfg_err) == V_ERR[i], {tag(i), " cfg_err"}, int'(cfg_err), V_ERR[i]);
         run_en(40, t1, t2, t3, cnt);
         if (V_ERR[i] != 0) begin
            chk(cnt == 0, "R3 pulses while in error", cnt, 0);
         end else begin
            chk(t1 == V_FST[i], {tag(i), " first pulse"}, t1, V_FST[i]);
            chk(t2 - t1 == V_PER[i], {tag(i), " period 1"}, t2 - t1, V_PER[i]);
            chk(t3 - t2 == V_PER[i], {tag(i), " period 2"}, t3 - t2, V_PER[i]);
         end
      end

      // R7: short disable clears accumulator and count
      setup(4, 16, 4, 0, 0);
      run_en(7, t1, t2, t3, cnt);
      @(negedge clk);
      enable = 1'b0;
      @(posedge clk);
      run_en(20, t1, t2, t3, cnt);
      chk(t1 == 4, "R7 first pulse after re-enable", t1, 4);
      chk(t2 == 9, "R7 second pulse after re-enable", t2, 9);

      // R2: settings changed while enabled are ignored
      setup(4, 16, 0, 0, 0);
      t1 = 0; t2 = 0; t3 = 0; cnt = 0;
      @(negedge clk);
      enable = 1'b1;
      for (int e = 1; e <= 13; e++) begin
         @(posedge clk);
         #1;
         if (tick) begin
            cnt++;
            if (cnt == 3) t3 = e;
         end
         if (e == 2) begin
            div    = DIV_W'(1);
            delta  = FRAC_W'(4);
            bypass = 1'b1;
         end
      end
      chk(cnt == 3, "R2 pulse count", cnt, 3);
      chk(t3 == 12, "R2 third pulse edge", t3, 12);
      chk(cfg_err == 1'b0, "R2 cfg_err unchanged", int'(cfg_err), 0);

      // R5: long-run mean, lengthened
      setup(3, 32, 8, 0, 0);
      run_en(300, t1, t2, t3, cnt);
      ex = (300 * 32) / ((32 + 8) * 3);
      chk(cnt >= ex - 1 && cnt <= ex + 1, "R5 mean pulse count", cnt, ex);

      // R6: long-run mean, shortened
      setup(3, 32, 8, 1, 0);
      run_en(300, t1, t2, t3, cnt);
      ex = (300 * 32) / ((32 - 8) * 3);
      chk(cnt >= ex - 1 && cnt <= ex + 1, "R6 mean pulse count", cnt, ex);

      // R3: magnitude just under half the period is accepted
      setup(4, 16, 7, 0, 0);
      chk(cfg_err == 1'b0, "R3 boundary accepted", int'(cfg_err), 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule